// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block collects the interrupt causes of a classic byte-wide UART register file and turns them into one interrupt request and an identification code. The receiver, the transmitter and the modem-line sampler report to it through single-cycle event pulses and level signals. The host side delivers already-decoded one-cycle read and write strobes for the enable, identification, line-status, modem-status, receive-buffer and transmit-holding registers.

The block keeps three kinds of state: the interrupt enable bits, the sticky receive error flags with data-ready, and the pending state of the holding-empty and modem-change sources. From that state it drives the interrupt line and the read values of the enable, identification and line-status registers. Each source is cleared by its own register access. When several enabled sources are pending at once, a fixed priority decides which one the identification register reports.

Top module: `uart_irq_ident`

## Requirements
- R1: During and after the active-high reset, the enable register reads 0x00, `intr` is low and the identification register reads 0x01.
- R2: A write to the enable register stores data bits 3:0. Bit 0 enables received data, bit 1 holding-register empty, bit 2 line status and bit 3 modem change. Bits above 3 read as zero. Without a write the value does not change.
- R3: `intr` is high exactly when at least one pending source has its enable bit set. Clearing an enable bit masks its source from the next cycle on, and setting the bit again brings the still-pending source back.
- R4: The identification register has bit 0 low while an enabled source is pending, and its bits 2:1 name the highest such source. The ranking is line status (0x06), then received data (0x04), then holding empty (0x02), then modem change (0x00). With nothing pending it reads 0x01.
- R5: Overrun, parity, framing and break events set line-status bits 1, 2, 3 and 4, and these bits stay set. Any of them being set is the line-status source. A line-status read clears all four from the next cycle. An error event in the same cycle as that read remains set.
- R6: A received-byte event sets line-status bit 0 (data ready), which is the received-data source. Only a receive-buffer read clears it: line-status and identification reads leave it set. An event in the same cycle as the buffer read leaves it set.
- R7: The holding-empty source becomes pending when `hold_empty` rises. It clears on a transmit-holding write, or on an identification read while the register reports 0x02. An identification read that reports another code leaves it pending.
- R8: Writing the enable register so that bit 1 goes from 0 to 1 while `hold_empty` is high makes the holding-empty source pending.
- R9: A modem-change event makes the modem source pending whatever the enable register holds. A modem-status read clears it.
- R10: Line-status bit 5 follows `hold_empty` and bit 6 follows `shift_empty` in the same cycle. Bit 7 reads zero, so an idle transmitter with no receive state reads 0x60.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| ier_wr | input | 1 | Enable register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| wdata | input | REG_W | Host write data |
| rx_byte_evt | input | 1 | Pulse: a byte was received |
| overrun_evt | input | 1 | Pulse: overrun error |
| parity_evt | input | 1 | Pulse: parity error |
| framing_evt | input | 1 | Pulse: framing error |
| break_evt | input | 1 | Pulse: break detected |
| modem_chg_evt | input | 1 | Pulse: a modem input changed |
| hold_empty | input | 1 | Level: transmit holding register is empty |
| shift_empty | input | 1 | Level: transmit shift register is empty |
| intr | output | 1 | Interrupt request |
| iir_q | output | REG_W | Identification register read value |
| ier_q | output | REG_W | Enable register read value |
| lsr_q | output | REG_W | Line-status register read value |

## Verification
The bench drives four sources pending at the same time and then peels them off one access at a time. A wrong ranking or a wrong clear would show a different code sequence than 0x06, 0x04, 0x02, 0x00, 0x01. It reads the identification register while it reports received data and then checks that the holding-empty source survives. A design that cleared holding-empty on any identification read would drop that interrupt. It lines up error and byte events with the read that clears them in the same cycle. A design that gave the clear priority would lose an event. It also turns enable bits off and on around a pending source, and arms holding-empty by enabling it while the register is already empty. A design that cleared the flag under the mask, or that needed a fresh edge to arm, would then keep `intr` low.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   // Source index doubles as the identification code in bits 2:1.
   typedef enum logic [1:0] {
      SRC_MDM  = 2'd0,
      SRC_THRE = 2'd1,
      SRC_RDA  = 2'd2,
      SRC_LINE = 2'd3
   } uirq_src_e;

   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned ERR_W   = 4;

   // Enable register bit positions
   localparam int unsigned EN_RDA  = 0;
   localparam int unsigned EN_THRE = 1;
   localparam int unsigned EN_LINE = 2;
   localparam int unsigned EN_MDM  = 3;

   // Line-status register bit positions
   localparam int unsigned LS_DR    = 0;
   localparam int unsigned LS_ERR_L = 1;
   localparam int unsigned LS_HE    = 5;
   localparam int unsigned LS_SE    = 6;

endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
   import uirq_pkg::*;
#(
   parameter int unsigned REG_W         = 8,
   parameter bit          ARM_ON_ENABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr,
   input  logic [REG_W-1:0]   wdata,
   input  logic               hold_empty,
   output logic [NUM_SRC-1:0] en_q,
   output logic               arm_thre
);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)     en_q <= '0;
      else if (wr) en_q <= wdata[NUM_SRC-1:0];
   end

   generate
      if (ARM_ON_ENABLE) begin : g_arm
         assign arm_thre = wr && wdata[EN_THRE] && !en_q[EN_THRE] && hold_empty;
      end else begin : g_no_arm
         assign arm_thre = 1'b0;
      end
   endgenerate

   p_en_hold_r2 : assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(en_q));

endmodule

// File: rtl/uirq_line_status.sv
module uirq_line_status
   import uirq_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_evt,
   input  logic [ERR_W-1:0] err_evt,
   input  logic             lsr_rd,
   input  logic             rbr_rd,
   input  logic             hold_empty,
   input  logic             shift_empty,
   output logic             dr_q,
   output logic             err_any,
   output logic [REG_W-1:0] lsr_val
);

   logic [ERR_W-1:0] err_q;

   // Sticky error flags: a new event beats the clearing read.
   always_ff @(posedge clk or posedge rst) begin
      if (rst)         err_q <= '0;
      else if (lsr_rd) err_q <= err_evt;
      else             err_q <= err_q | err_evt;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)         dr_q <= 1'b0;
      else if (rx_evt) dr_q <= 1'b1;
      else if (rbr_rd) dr_q <= 1'b0;
   end

   assign err_any = |err_q;

   always_comb begin
      lsr_val                           = '0;
      lsr_val[LS_DR]                    = dr_q;
      lsr_val[LS_ERR_L +: ERR_W]        = err_q;
      lsr_val[LS_HE]                    = hold_empty;
      lsr_val[LS_SE]                    = shift_empty;
   end

   p_err_clr_r5 : assert property (@(posedge clk) disable iff (rst)
      (lsr_rd && err_evt == '0) |=> (lsr_val[LS_ERR_L +: ERR_W] == '0));

   p_dr_keep_r6 : assert property (@(posedge clk) disable iff (rst)
      (dr_q && !rbr_rd) |=> dr_q);

endmodule

// File: rtl/uirq_pending.sv
module uirq_pending
   import uirq_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] en,
   input  logic               dr,
   input  logic               err_any,
   input  logic               hold_empty,
   input  logic               arm_thre,
   input  logic               thr_wr,
   input  logic               iir_rd,
   input  logic               msr_rd,
   input  logic               mdm_evt,
   output logic               intr,
   output logic [REG_W-1:0]   iir_val
);

   logic               thre_q, mdm_q, he_prev;
   logic [NUM_SRC-1:0] pend, act;
   logic [1:0]         id;
   logic               any;
   logic               thre_set, thre_clr;

   always_comb begin
      pend           = '0;
      pend[SRC_LINE] = err_any;
      pend[SRC_RDA]  = dr;
      pend[SRC_THRE] = thre_q;
      pend[SRC_MDM]  = mdm_q;
      act            = '0;
      act[SRC_LINE]  = pend[SRC_LINE] & en[EN_LINE];
      act[SRC_RDA]   = pend[SRC_RDA]  & en[EN_RDA];
      act[SRC_THRE]  = pend[SRC_THRE] & en[EN_THRE];
      act[SRC_MDM]   = pend[SRC_MDM]  & en[EN_MDM];
   end

   // Highest index wins: the source enum is ordered by rank.
   always_comb begin
      id  = '0;
      any = |act;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (act[i]) id = i[1:0];
      end
   end

   assign thre_set = (hold_empty && !he_prev) || arm_thre;
   assign thre_clr = thr_wr || (iir_rd && any && id == SRC_THRE);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         thre_q  <= 1'b0;
         mdm_q   <= 1'b0;
         he_prev <= 1'b1;
      end else begin
         he_prev <= hold_empty;
         if (thre_set)      thre_q <= 1'b1;
         else if (thre_clr) thre_q <= 1'b0;
         if (mdm_evt)       mdm_q  <= 1'b1;
         else if (msr_rd)   mdm_q  <= 1'b0;
      end
   end

   assign intr = any;

   always_comb begin
      iir_val      = '0;
      iir_val[0]   = !any;
      iir_val[2:1] = id;
   end

   p_intr_iir_r3 : assert property (@(posedge clk) disable iff (rst)
      intr == !iir_val[0]);

   p_prio_line_r4 : assert property (@(posedge clk) disable iff (rst)
      (err_any && en[EN_LINE]) |-> (iir_val[3:0] == 4'h6));

   p_mdm_clr_r9 : assert property (@(posedge clk) disable iff (rst)
      (msr_rd && !mdm_evt) |=> (iir_val[2:0] != 3'b000));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uirq_pkg::*;
#(
   parameter int unsigned REG_W         = 8,
   parameter bit          ARM_ON_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ier_wr,
   input  logic             iir_rd,
   input  logic             lsr_rd,
   input  logic             msr_rd,
   input  logic             rbr_rd,
   input  logic             thr_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             rx_byte_evt,
   input  logic             overrun_evt,
   input  logic             parity_evt,
   input  logic             framing_evt,
   input  logic             break_evt,
   input  logic             modem_chg_evt,
   input  logic             hold_empty,
   input  logic             shift_empty,
   output logic             intr,
   output logic [REG_W-1:0] iir_q,
   output logic [REG_W-1:0] ier_q,
   output logic [REG_W-1:0] lsr_q
);

   localparam int unsigned MIN_W = LS_SE + 2;

   generate
      if (REG_W < MIN_W) begin : g_bad_width
         $error("uart_irq_ident: REG_W must be at least %0d", MIN_W);
      end
   endgenerate

   logic [NUM_SRC-1:0] en;
   logic               arm_thre;
   logic               dr, err_any;
   logic [ERR_W-1:0]   err_evt;

   assign err_evt = {break_evt, framing_evt, parity_evt, overrun_evt};

   uirq_enable_reg #(.REG_W(REG_W), .ARM_ON_ENABLE(ARM_ON_ENABLE)) u_en (
      .clk        (clk),
      .rst        (rst),
      .wr         (ier_wr),
      .wdata      (wdata),
      .hold_empty (hold_empty),
      .en_q       (en),
      .arm_thre   (arm_thre)
   );

   uirq_line_status #(.REG_W(REG_W)) u_ls (
      .clk         (clk),
      .rst         (rst),
      .rx_evt      (rx_byte_evt),
      .err_evt     (err_evt),
      .lsr_rd      (lsr_rd),
      .rbr_rd      (rbr_rd),
      .hold_empty  (hold_empty),
      .shift_empty (shift_empty),
      .dr_q        (dr),
      .err_any     (err_any),
      .lsr_val     (lsr_q)
   );

   uirq_pending #(.REG_W(REG_W)) u_pend (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .dr         (dr),
      .err_any    (err_any),
      .hold_empty (hold_empty),
      .arm_thre   (arm_thre),
      .thr_wr     (thr_wr),
      .iir_rd     (iir_rd),
      .msr_rd     (msr_rd),
      .mdm_evt    (modem_chg_evt),
      .intr       (intr),
      .iir_val    (iir_q)
   );

   always_comb begin
      ier_q                = '0;
      ier_q[NUM_SRC-1:0]   = en;
   end

   p_rda_clr_r6 : assert property (@(posedge clk) disable iff (rst)
      (rbr_rd && !rx_byte_evt) |=> !lsr_q[LS_DR]);

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

   localparam int REG_W = 8;
   localparam int M_IER = 1 << 0;
   localparam int M_IIR = 1 << 1;
   localparam int M_LSR = 1 << 2;
   localparam int M_MSR = 1 << 3;
   localparam int M_RBR = 1 << 4;
   localparam int M_THR = 1 << 5;
   localparam int M_RX  = 1 << 6;
   localparam int M_OVR = 1 << 7;
   localparam int M_PAR = 1 << 8;
   localparam int M_FRM = 1 << 9;
   localparam int M_BRK = 1 << 10;
   localparam int M_MDM = 1 << 11;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ier_wr = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0, rbr_rd = 0, thr_wr = 0;
   logic [REG_W-1:0] wdata = '0;
   logic rx_byte_evt = 0, overrun_evt = 0, parity_evt = 0, framing_evt = 0;
   logic break_evt = 0, modem_chg_evt = 0;
   logic hold_empty = 1, shift_empty = 1;
   logic intr;
   logic [REG_W-1:0] iir_q, ier_q, lsr_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_irq_ident #(.REG_W(REG_W)) u0 (
      .clk(clk), .rst(rst), .ier_wr(ier_wr), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
      .msr_rd(msr_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr), .wdata(wdata),
      .rx_byte_evt(rx_byte_evt), .overrun_evt(overrun_evt), .parity_evt(parity_evt),
      .framing_evt(framing_evt), .break_evt(break_evt), .modem_chg_evt(modem_chg_evt),
      .hold_empty(hold_empty), .shift_empty(shift_empty),
      .intr(intr), .iir_q(iir_q), .ier_q(ier_q), .lsr_q(lsr_q)
   );

   // ---------------- reference model ----------------
   logic [3:0] m_ier;
   logic [3:0] m_err;
   logic       m_dr, m_thre, m_mdm, m_he;

   function automatic logic [7:0] exp_iir();
      if (m_err != 0 && m_ier[2]) return 8'h06;
      if (m_dr && m_ier[0])       return 8'h04;
      if (m_thre && m_ier[1])     return 8'h02;
      if (m_mdm && m_ier[3])      return 8'h00;
      return 8'h01;
   endfunction

   function automatic logic [7:0] exp_lsr();
      return {1'b0, shift_empty, hold_empty, m_err, m_dr};
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_ier = 0; m_err = 0; m_dr = 0; m_thre = 0; m_mdm = 0; m_he = 1;
      end else begin
         logic [7:0] cur;
         logic       arm;
         logic [3:0] ev;
         cur = exp_iir();
         arm = ier_wr && wdata[1] && !m_ier[1] && hold_empty;
         ev  = {break_evt, framing_evt, parity_evt, overrun_evt};
         if (ier_wr) m_ier = wdata[3:0];
         if (lsr_rd) m_err = ev; else m_err = m_err | ev;
         if (rx_byte_evt) m_dr = 1; else if (rbr_rd) m_dr = 0;
         if ((hold_empty && !m_he) || arm) m_thre = 1;
         else if (thr_wr || (iir_rd && cur == 8'h02)) m_thre = 0;
         m_he = hold_empty;
         if (modem_chg_evt) m_mdm = 1; else if (msr_rd) m_mdm = 0;
      end
   end

   // Compare on every cycle, away from the active edge.
   always @(negedge clk) begin
      if (!rst && !done) begin
         checks++;
         if (intr !== (exp_iir() != 8'h01)) begin
            errors++;
            $display("FAIL R3 model intr actual %0b expected %0b", intr, exp_iir() != 8'h01);
         end
         if (iir_q !== exp_iir()) begin
            errors++;
            $display("FAIL R4 model iir actual %02h expected %02h", iir_q, exp_iir());
         end
         if (ier_q !== {4'h0, m_ier}) begin
            errors++;
            $display("FAIL R2 model ier actual %02h expected %02h", ier_q, {4'h0, m_ier});
         end
         if (lsr_q !== exp_lsr()) begin
            errors++;
            $display("FAIL R5 model lsr actual %02h expected %02h", lsr_q, exp_lsr());
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input int m, input logic [7:0] wd = 8'h00);
      @(negedge clk); #1;
      ier_wr = m[0]; iir_rd = m[1]; lsr_rd = m[2]; msr_rd = m[3];
      rbr_rd = m[4]; thr_wr = m[5]; rx_byte_evt = m[6]; overrun_evt = m[7];
      parity_evt = m[8]; framing_evt = m[9]; break_evt = m[10]; modem_chg_evt = m[11];
      wdata = wd;
      @(posedge clk); #1;
      ier_wr = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0; rbr_rd = 0; thr_wr = 0;
      rx_byte_evt = 0; overrun_evt = 0; parity_evt = 0; framing_evt = 0;
      break_evt = 0; modem_chg_evt = 0;
   endtask

   task automatic set_tx(input logic he, input logic se);
      @(negedge clk); #1;
      hold_empty = he; shift_empty = se;
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "ier in reset", ier_q, 8'h00);
      chk("R1", "intr in reset", {7'd0, intr}, 8'h00);
      @(negedge clk); rst = 0;
      @(posedge clk); #1;
      chk("R1", "iir after reset", iir_q, 8'h01);
      chk("R1", "intr after reset", {7'd0, intr}, 8'h00);
      chk("R10", "lsr idle", lsr_q, 8'h60);

      // R2 upper bits dropped; R8 arming on enable
      cyc(M_IER, 8'hFF);
      chk("R2", "ier upper bits", ier_q, 8'h0F);
      chk("R8", "arm on enable", iir_q, 8'h02);
      cyc(M_IER, 8'h04);
      chk("R3", "masked thre", {7'd0, intr}, 8'h00);

      // R5 overrun and its clear
      cyc(M_RX | M_OVR);
      chk("R4", "line status code", iir_q, 8'h06);
      chk("R5", "overrun set", lsr_q, 8'h63);
      cyc(M_LSR);
      chk("R5", "intr after lsr read", {7'd0, intr}, 8'h00);
      chk("R5", "overrun cleared", lsr_q, 8'h61);
      cyc(M_RBR);
      chk("R6", "dr cleared by rbr", lsr_q, 8'h60);

      // R6 received data survives other reads
      cyc(M_IER, 8'h01);
      cyc(M_RX);
      chk("R4", "rda code", iir_q, 8'h04);
      cyc(M_LSR);
      chk("R6", "rda after lsr read", iir_q, 8'h04);
      cyc(M_IIR);
      chk("R6", "rda after iir read", iir_q, 8'h04);
      cyc(M_RBR);
      chk("R6", "rda cleared", iir_q, 8'h01);

      // R4 priority ladder with all four pending
      cyc(M_IER, 8'h0F);
      cyc(M_PAR | M_RX | M_MDM);
      chk("R4", "top is line", iir_q, 8'h06);
      chk("R5", "parity bit", lsr_q, 8'h65);
      cyc(M_LSR);
      chk("R4", "next is rda", iir_q, 8'h04);
      cyc(M_RBR);
      chk("R4", "next is thre", iir_q, 8'h02);
      cyc(M_IIR);
      chk("R7", "iir read clears thre", iir_q, 8'h00);
      cyc(M_MSR);
      chk("R9", "msr read clears modem", iir_q, 8'h01);

      // R3 masking keeps the flag
      cyc(M_RX);
      cyc(M_IER, 8'h00);
      chk("R3", "masked intr", {7'd0, intr}, 8'h00);
      chk("R3", "masked iir", iir_q, 8'h01);
      cyc(M_IER, 8'h01);
      chk("R3", "unmasked iir", iir_q, 8'h04);
      cyc(M_RBR);

      // R7 holding-empty cycle
      cyc(M_IER, 8'h03);
      chk("R8", "arm again", iir_q, 8'h02);
      set_tx(1'b0, 1'b0);
      cyc(M_THR);
      chk("R7", "thr write clears", iir_q, 8'h01);
      chk("R10", "lsr tx busy", lsr_q, 8'h00);
      repeat (4) cyc(0);
      set_tx(1'b1, 1'b0);
      chk("R7", "rise sets thre", iir_q, 8'h02);
      chk("R10", "lsr holding empty only", lsr_q, 8'h20);
      cyc(M_RX);
      cyc(M_IIR);
      cyc(M_RBR);
      chk("R7", "iir read on rda keeps thre", iir_q, 8'h02);
      cyc(M_THR);
      chk("R7", "thre cleared", iir_q, 8'h01);

      // R5 coincident set and clear
      set_tx(1'b1, 1'b1);
      cyc(M_IER, 8'h04);
      cyc(M_FRM);
      chk("R5", "framing bit", lsr_q, 8'h68);
      cyc(M_LSR | M_BRK);
      chk("R5", "break kept on read", lsr_q, 8'h70);
      cyc(M_LSR);
      chk("R5", "all errors cleared", lsr_q, 8'h60);
      cyc(M_RX | M_RBR);
      chk("R6", "rx beats rbr read", lsr_q, 8'h61);
      cyc(M_RBR);

      // R9 modem source latched under mask
      cyc(M_MDM);
      chk("R9", "modem masked", {7'd0, intr}, 8'h00);
      cyc(M_IER, 8'h08);
      chk("R9", "modem code", iir_q, 8'h00);
      cyc(M_MSR);
      chk("R9", "modem cleared", iir_q, 8'h01);

      repeat (3) cyc(0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule